// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns a demodulated infrared receiver line into 32-bit command frames. The line is high while a carrier burst (a mark) is present and low during a gap (a space). A single tick counter, which advances only on a time-base enable, measures each interval. Each interval is then compared against a set of programmable timing windows: leader mark, data-leader space, repeat-leader space, logic-0 period and logic-1 period. A data bit is measured from the rising edge of its mark to the rising edge of the next mark.

After a valid leader mark, the following space decides what comes next. A long space starts a 32-bit data frame, received least significant bit first. A short space signals a repeat of the last key. A completed frame is loaded into the frame register in one cycle, together with a one-clock done strobe. A repeat only sets the repeat flag and strobes done. Any interval that fits no window abandons the frame and flags a data error. An interval that grows past the largest upper limit allowed at that step is abandoned at once, without waiting for the next edge.

The block sits behind a register interface that provides the windows, the enable and the soft reset. A prescaler outside the block supplies the tick, typically one tick per 20 µs.

Top module: `ir_pd_decoder`

## Requirements
- R1: After rst_ni is released, frame_o is 0, status_o is 0 and done_o is low.
- R2: A leader mark, then a data-leader space, then 32 accepted bit periods load frame_o in a single cycle. The first bit received lands in frame_o[0], so the address sits in bits 15:0 and the command in bits 23:16. In that same cycle done_o is high for exactly one clock and status_o[0] and status_o[2] are cleared.
- R3: A leader mark followed by a space inside the repeat window raises done_o for one clock and sets status_o[0] to 1, leaving frame_o unchanged.
- R4: The bit period is measured from one mark rising edge to the next. A period inside the logic-0 window gives bit value 0, and a period inside the logic-1 window gives 1. Logic 0 is checked first where the windows overlap.
- R5: A bit period or leader space that falls in no window abandons the frame without done_o and sets status_o[2] (data error). frame_o is left unchanged.
- R6: A leader mark whose width falls outside its window is dropped silently: no done_o, status_o unchanged, and the decoder returns to idle.
- R7: Once the running count exceeds every upper limit that could still match at the current step, the frame is abandoned (status_o[2] set, status_o[1] cleared) without waiting for an edge.
- R8: Intervals are counted only on clocks where tick_i is high, so the same tick counts decode identically at any tick rate.
- R9: Every window input holds the upper limit in bits 31:16 and the lower limit in bits 15:0, both inclusive and in ticks. Reprogramming the windows changes which timings are accepted.
- R10: While enable_i is low, the decoder stays idle (status_o[1] = 0) and ignores ir_i. frame_o and status flags keep their values.
- R11: A clock with soft_rst_i high clears frame_o and status_o and returns the decoder to idle.
- R12: status_o[1] (busy) is high while a leader or frame is being measured, and low when idle, including in the cycle done_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Decoder enable; low holds it idle |
| soft_rst_i | input | 1 | Synchronous clear of decoder, frame and status |
| ir_i | input | 1 | Demodulated IR line, high during a mark |
| tick_i | input | 1 | Time-base tick enable for the interval counter |
| win_lead_mark_i | input | 32 | Leader mark window {max, min} |
| win_lead_data_i | input | 32 | Leader space window that starts a data frame |
| win_lead_rpt_i | input | 32 | Leader space window that marks a repeat |
| win_bit0_i | input | 32 | Logic-0 bit period window |
| win_bit1_i | input | 32 | Logic-1 bit period window |
| frame_o | output | 32 | Last completed frame |
| status_o | output | 3 | {data error, busy, repeat} |
| done_o | output | 1 | One-clock strobe on frame or repeat completion |

## Verification
Properties cover the invariants on every cycle:
- done_o lasts a single clock and never coincides with busy or a data error.
- frame_o changes only with done_o or after a soft reset, and never on a repeat.
- A data error is never raised together with done_o.
- Disable and soft reset force the idle and cleared states.

The timing-dependent behaviour is shown only by the directed scenarios:
- least-significant-bit-first assembly and field placement;
- classification of periods into the logic-0 and logic-1 windows;
- the early abort on an overlong space;
- independence from the tick rate;
- acceptance that follows reprogrammed windows.

// File: rtl/ir_pd_pkg.sv
`timescale 1ns/1ps
package ir_pd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LMARK  = 2'd1,
    ST_LSPACE = 2'd2,
    ST_DATA   = 2'd3
  } dec_state_e;

  localparam int unsigned WIN_NUM = 5;
  localparam int unsigned WI_LMARK = 0;
  localparam int unsigned WI_LDATA = 1;
  localparam int unsigned WI_LRPT  = 2;
  localparam int unsigned WI_BIT0  = 3;
  localparam int unsigned WI_BIT1  = 4;
endpackage

// File: rtl/ir_tick_counter.sv
`timescale 1ns/1ps
module ir_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1; // saturate
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ir_win_bank.sv
`timescale 1ns/1ps
module ir_win_bank #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WIN_NUM = 5
) (
  input  logic [WIN_NUM-1:0][2*CNT_W-1:0] win_i,
  input  logic [CNT_W-1:0]                cnt_i,
  output logic [WIN_NUM-1:0]              in_o,
  output logic [WIN_NUM-1:0]              over_o
);
  for (genvar g = 0; g < WIN_NUM; g++) begin : g_win
    logic [CNT_W-1:0] lim_hi, lim_lo;
    assign lim_hi    = win_i[g][2*CNT_W-1:CNT_W];
    assign lim_lo    = win_i[g][CNT_W-1:0];
    assign in_o[g]   = (cnt_i >= lim_lo) && (cnt_i <= lim_hi);
    assign over_o[g] = (cnt_i > lim_hi);
  end
endmodule

// File: rtl/ir_pd_fsm.sv
`timescale 1ns/1ps
module ir_pd_fsm
  import ir_pd_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  soft_rst_i,
  input  logic                  ir_i,
  input  logic [WIN_NUM-1:0]    in_win_i,
  input  logic [WIN_NUM-1:0]    over_win_i,
  output logic                  clr_cnt_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [2:0]            status_o,
  output logic                  done_o
);
  localparam int unsigned BC_W = $clog2(FRAME_BITS);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_BITS - 1);

  dec_state_e            state_q, state_d;
  logic                  ir_q;
  logic [BC_W-1:0]       bit_cnt_q;
  logic [FRAME_BITS-1:0] shreg_q, frame_q;
  logic                  rpt_q, err_q, done_q;
  logic                  rise, fall;
  logic                  bit_ld, bit_val, abort, fin_frame, fin_rpt;

  assign rise = ir_i & ~ir_q;
  assign fall = ~ir_i & ir_q;

  always_comb begin
    state_d   = state_q;
    bit_ld    = 1'b0;
    bit_val   = 1'b0;
    abort     = 1'b0;
    fin_frame = 1'b0;
    fin_rpt   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (rise) state_d = ST_LMARK;
      ST_LMARK: begin
        if (fall) state_d = in_win_i[WI_LMARK] ? ST_LSPACE : ST_IDLE;
        else if (over_win_i[WI_LMARK]) state_d = ST_IDLE;   // dropped quietly
      end
      ST_LSPACE: begin
        if (rise) begin
          if (in_win_i[WI_LDATA]) state_d = ST_DATA;
          else if (in_win_i[WI_LRPT]) begin
            fin_rpt = 1'b1;
            state_d = ST_IDLE;
          end else begin
            abort   = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (over_win_i[WI_LDATA] && over_win_i[WI_LRPT]) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (rise) begin
          if (in_win_i[WI_BIT0] || in_win_i[WI_BIT1]) begin
            bit_ld  = 1'b1;
            bit_val = ~in_win_i[WI_BIT0];  // logic 0 wins on overlap
            if (bit_cnt_q == LAST_BIT) begin
              fin_frame = 1'b1;
              state_d   = ST_IDLE;
            end
          end else begin
            abort   = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (over_win_i[WI_BIT0] && over_win_i[WI_BIT1]) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // counter restarts at every step boundary and at each data mark edge
  assign clr_cnt_o = soft_rst_i || !enable_i || (state_d != state_q) ||
                     ((state_q == ST_DATA) && rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ir_q      <= 1'b0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      frame_q   <= '0;
      rpt_q     <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ir_q   <= ir_i;
      done_q <= 1'b0;
      if (soft_rst_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        shreg_q   <= '0;
        frame_q   <= '0;
        rpt_q     <= 1'b0;
        err_q     <= 1'b0;
      end else if (!enable_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
      end else begin
        state_q <= state_d;
        if (state_q == ST_LSPACE && state_d == ST_DATA) bit_cnt_q <= '0;
        if (bit_ld) begin
          shreg_q   <= {bit_val, shreg_q[FRAME_BITS-1:1]};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (fin_frame) begin
          frame_q <= {bit_val, shreg_q[FRAME_BITS-1:1]};
          done_q  <= 1'b1;
          rpt_q   <= 1'b0;
          err_q   <= 1'b0;
        end
        if (fin_rpt) begin
          done_q <= 1'b1;
          rpt_q  <= 1'b1;
          err_q  <= 1'b0;
        end
        if (abort) err_q <= 1'b1;
      end
    end
  end

  assign frame_o  = frame_q;
  assign status_o = {err_q, (state_q != ST_IDLE), rpt_q};
  assign done_o   = done_q;
endmodule

// File: rtl/ir_pd_decoder.sv
`timescale 1ns/1ps
module ir_pd_decoder
  import ir_pd_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  soft_rst_i,
  input  logic                  ir_i,
  input  logic                  tick_i,
  input  logic [2*CNT_W-1:0]    win_lead_mark_i,
  input  logic [2*CNT_W-1:0]    win_lead_data_i,
  input  logic [2*CNT_W-1:0]    win_lead_rpt_i,
  input  logic [2*CNT_W-1:0]    win_bit0_i,
  input  logic [2*CNT_W-1:0]    win_bit1_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [2:0]            status_o,
  output logic                  done_o
);
  localparam int unsigned WIN_W = 2 * CNT_W;

  logic [WIN_NUM-1:0][WIN_W-1:0] win_all;
  logic [CNT_W-1:0]              cnt;
  logic                          clr_cnt;
  logic [WIN_NUM-1:0]            in_win, over_win;

  assign win_all[WI_LMARK] = win_lead_mark_i;
  assign win_all[WI_LDATA] = win_lead_data_i;
  assign win_all[WI_LRPT]  = win_lead_rpt_i;
  assign win_all[WI_BIT0]  = win_bit0_i;
  assign win_all[WI_BIT1]  = win_bit1_i;

  ir_tick_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_cnt),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  ir_win_bank #(.CNT_W(CNT_W), .WIN_NUM(WIN_NUM)) i_win (
    .win_i  (win_all),
    .cnt_i  (cnt),
    .in_o   (in_win),
    .over_o (over_win)
  );

  ir_pd_fsm #(.FRAME_BITS(FRAME_BITS)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .soft_rst_i (soft_rst_i),
    .ir_i       (ir_i),
    .in_win_i   (in_win),
    .over_win_i (over_win),
    .clr_cnt_o  (clr_cnt),
    .frame_o    (frame_o),
    .status_o   (status_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/ir_pd_checker.sv
`timescale 1ns/1ps
module ir_pd_checker #(
  parameter int unsigned FRAME_BITS = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  enable_i,
  input logic                  soft_rst_i,
  input logic [FRAME_BITS-1:0] frame_o,
  input logic [2:0]            status_o,
  input logic                  done_o
);
  AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                            // R2
  AST_DONE_CLEARS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !status_o[2]);                                       // R2
  AST_FRAME_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> (done_o || $past(soft_rst_i)));           // R2
  AST_RPT_KEEPS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[0]) |-> $stable(frame_o));                  // R3
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> !done_o);                                // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !soft_rst_i) |=> !status_o[1]);                   // R10
  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (frame_o == '0 && status_o == 3'b000));          // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !status_o[1]);                                       // R12
endmodule

bind ir_pd_decoder ir_pd_checker #(.FRAME_BITS(FRAME_BITS)) i_ir_pd_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .soft_rst_i (soft_rst_i),
  .frame_o    (frame_o),
  .status_o   (status_o),
  .done_o     (done_o)
);

// File: tb/test_ir_pd_decoder.sv
`timescale 1ns/1ps
module test_ir_pd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        ir_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] win_lead_mark_i, win_lead_data_i, win_lead_rpt_i, win_bit0_i, win_bit1_i;
  logic [31:0] frame_o;
  logic [2:0]  status_o;
  logic        done_o;

  int total = 0, bad = 0, done_cnt = 0, tdiv = 1, div_cnt = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ir_pd_decoder i_ir_pd_decoder (
    .clk_i, .rst_ni, .enable_i, .soft_rst_i, .ir_i, .tick_i,
    .win_lead_mark_i, .win_lead_data_i, .win_lead_rpt_i, .win_bit0_i, .win_bit1_i,
    .frame_o, .status_o, .done_o
  );

  always @(negedge clk_i) begin
    div_cnt = (div_cnt + 1 >= tdiv) ? 0 : div_cnt + 1;
    tick_i <= (div_cnt == 0);
    if (rst_ni && done_o) done_cnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      while (!tick_i) @(posedge clk_i);
    end
    @(negedge clk_i);
  endtask

  task automatic pulse(int mark, int space);
    ir_i = 1'b1; wait_ticks(mark);
    ir_i = 1'b0; wait_ticks(space);
  endtask

  task automatic set_default_windows();
    win_lead_mark_i = {16'd500, 16'd400};
    win_lead_data_i = {16'd300, 16'd200};
    win_lead_rpt_i  = {16'd150, 16'd80};
    win_bit0_i      = {16'd72,  16'd40};
    win_bit1_i      = {16'd134, 16'd90};
  endtask

  task automatic send_frame(logic [31:0] w, int lm = 450, int ls = 250,
                            int bm = 28, int p0 = 56, int p1 = 112);
    pulse(lm, ls);
    for (int b = 0; b < 32; b++) pulse(bm, (w[b] ? p1 : p0) - bm);
    pulse(bm, 200);
  endtask

  task automatic send_repeat();
    pulse(450, 112);
    pulse(28, 200);
  endtask

  task automatic t_reset();
    check("R1 frame", frame_o, 32'h0);
    check("R1 status", {29'h0, status_o}, 32'h0);
    check("R1 done", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_frame(logic [31:0] w);
    int d0 = done_cnt;
    send_frame(w);
    check("R2 frame", frame_o, w);
    check("R2 command field", {24'h0, frame_o[23:16]}, {24'h0, w[23:16]});
    check("R2 single done", done_cnt - d0, 1);
    check("R2/R12 status", {29'h0, status_o}, 32'h0);
  endtask

  task automatic t_repeat();
    int d0 = done_cnt;
    logic [31:0] f0 = frame_o;
    send_repeat();
    check("R3 done", done_cnt - d0, 1);
    check("R3 repeat flag", {29'h0, status_o}, 32'h1);
    check("R3 frame kept", frame_o, f0);
  endtask

  task automatic t_bad_bit();
    int d0 = done_cnt;
    logic [31:0] f0 = frame_o;
    pulse(450, 250);
    for (int b = 0; b < 5; b++) pulse(28, 28);
    pulse(28, 52);          // period 80: between bit windows
    pulse(28, 200);
    check("R5 no done", done_cnt - d0, 0);
    check("R5 error status", {29'h0, status_o}, 32'h4);
    check("R5 frame kept", frame_o, f0);
  endtask

  task automatic t_bad_leader();
    int d0 = done_cnt;
    logic [2:0] s0 = status_o;
    pulse(300, 400);
    check("R6 no done", done_cnt - d0, 0);
    check("R6 status kept", {29'h0, status_o}, {29'h0, s0});
  endtask

  task automatic t_timeout();
    send_frame(32'h55AA_00FF);
    check("R4 bit pattern", frame_o, 32'h55AA_00FF);
    pulse(450, 250);
    ir_i = 1'b1; wait_ticks(28);
    ir_i = 1'b0; wait_ticks(60);
    check("R12 busy mid frame", {29'h0, status_o}, 32'h2);
    wait_ticks(70);         // period now past 134 with line still low
    check("R7 early abort", {29'h0, status_o}, 32'h4);
    wait_ticks(100);
  endtask

  task automatic t_tick_rate();
    tdiv = 2;
    wait_ticks(4);
    send_frame(32'h35CA_1234);
    check("R8 frame at half tick rate", frame_o, 32'h35CA_1234);
    tdiv = 1;
    wait_ticks(4);
  endtask

  task automatic t_windows();
    int d0;
    logic [31:0] f0;
    win_lead_mark_i = {16'd250, 16'd200};
    win_lead_data_i = {16'd150, 16'd100};
    win_lead_rpt_i  = {16'd75,  16'd40};
    win_bit0_i      = {16'd36,  16'd20};
    win_bit1_i      = {16'd67,  16'd45};
    send_frame(32'hE619_41BE, 225, 125, 14, 28, 56);
    check("R9 scaled frame", frame_o, 32'hE619_41BE);
    d0 = done_cnt;
    f0 = frame_o;
    send_frame(32'h0000_0001);  // default timing no longer accepted
    check("R9 old timing rejected", done_cnt - d0, 0);
    check("R9 frame kept", frame_o, f0);
    set_default_windows();
  endtask

  task automatic t_disable();
    int d0 = done_cnt;
    logic [31:0] f0 = frame_o;
    logic [2:0] s0 = status_o;
    enable_i = 1'b0;
    send_frame(32'h1234_5678);
    check("R10 no done", done_cnt - d0, 0);
    check("R10 frame kept", frame_o, f0);
    check("R10 status kept", {29'h0, status_o}, {29'h0, s0});
    enable_i = 1'b1;
  endtask

  task automatic t_soft_reset();
    send_repeat();
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    check("R11 frame cleared", frame_o, 32'h0);
    check("R11 status cleared", {29'h0, status_o}, 32'h0);
  endtask

  initial begin
    #(20 * 180000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    set_default_windows();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    enable_i = 1'b1;
    wait_ticks(10);
    t_frame(32'h8F70_2AD5);
    t_repeat();
    t_frame(32'h00FF_FFFF);
    t_bad_bit();
    t_bad_leader();
    t_timeout();
    t_tick_rate();
    t_windows();
    t_disable();
    t_soft_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule